// File: doc/BRIEF.md
# Serial Management Slave for an Ethernet PHY

This block is the management port of a 10/100 Ethernet PHY. A station manager clocks it with MDC and talks to it over one open-drain MDIO line, which appears here as a sampled input, a data output and an output enable. The slave decodes serial frames, checks the PHY address they carry against its own, and reads or writes a small bank of 16-bit registers. Its own address comes from three strap pins. These are sampled while hardware reset is held and frozen once reset is released, so tying the straps low gives address 0.

The standard registers sit at addresses 0 to 6 and the vendor registers at 16 to 31. Addresses 7 to 15 have no storage. Bit 3 of register 17 is a promiscuous-address control: when it is set, the slave answers frames sent to any PHY address, which lets a single manager reach several identical devices with one broadcast frame. All logic runs on MDC and uses a synchronous active-low reset.

Frame layout, bits sent first to last: at least 32 ones of preamble, start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, a 2-bit turnaround, then 16 data bits sent MSB first.

Top module: `mdio_slave`

## Requirements
- R1: The PHY address is `{2'b00, strap}`, taken from the strap inputs on the last MDC edge with `rst_n` low. Strap changes after reset release have no effect: frames sent to the new strap value get no answer.
- R2: A read frame that matches leaves MDIO released (`mdio_oe`=0) during the first turnaround bit and drives 0 during the second. It then drives the 16 register bits MSB first, each updated just after a rising MDC edge.
- R3: A write frame that matches stores its 16 data bits into an implemented register (0..6 or 16..31) only after the last data bit is sampled. A later read returns the stored value.
- R4: A read of any register address from 7 to 15 returns 16'hFFFF. A write to those addresses changes nothing.
- R5: When bypass is off and the frame's PHY address differs from the latched address, the frame is followed to its end. MDIO is never driven and no register changes.
- R6: While bit 3 of register 17 is 1, read and write frames are served whatever their PHY address field is.
- R7: A malformed frame is dropped without driving MDIO and without a register update, and the slave goes back to hunting for a preamble. Malformed means fewer than 32 preamble ones, opcode `00` or `11`, or a write turnaround other than `10`.
- R8: `mdio_oe` is 0 out of reset. It is high only for the second turnaround bit and the 16 read data bits: exactly 17 consecutive MDC cycles per served read, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; every register in the block runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low hardware reset; the straps are sampled while it is low |
| phyad_strap | input | 3 | Strap pins that set the low bits of the PHY address |
| mdio_i | input | 1 | Level of the MDIO line as seen by the slave |
| mdio_o | output | 1 | Value the slave drives onto MDIO when enabled |
| mdio_oe | output | 1 | Output enable for the MDIO open-drain driver |

## Verification
The assertions watch, on every cycle, the behaviours that are visible locally:
- the strap-latched address never changes once reset is released;
- any register address from 7 to 15 always selects the all-ones value;
- the output enable rises only with a 0 on the line;
- the output is enabled only for a matched read, and never for more than 17 cycles in a row.

The bench scenarios cover what needs a full frame to show:
- write-then-read round trips into real storage;
- writes to empty addresses being lost;
- mismatched, short-preamble, bad-opcode and bad-turnaround frames leaving every register untouched;
- the bypass bit turning on answers to foreign addresses;
- strap changes after reset being ignored.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    typedef enum logic [2:0] {
        MS_HUNT,
        MS_START,
        MS_OP,
        MS_PHY,
        MS_REG,
        MS_TURN,
        MS_DATA
    } mdio_phase_e;

    // True when a register index has storage behind it.
    function automatic logic reg_present(input int unsigned idx,
                                         input int unsigned std_last,
                                         input int unsigned vend_first,
                                         input int unsigned vend_last);
        return (idx <= std_last) || ((idx >= vend_first) && (idx <= vend_last));
    endfunction

endpackage

// File: rtl/mdio_strap_latch.sv
module mdio_strap_latch #(
    parameter int SW = 3,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] strap,
    output logic [AW-1:0] phy_addr
);

    logic [SW-1:0] addr_d, addr_q;

    // Track the straps during reset, freeze once reset is released.
    always_comb begin
        addr_d = addr_q;
        if (!rst_n) begin
            addr_d = strap;
        end
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
    end

    assign phy_addr = AW'(addr_q);

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_slave_pkg::*;
#(
    parameter int AW         = 5,
    parameter int DW         = 16,
    parameter int STD_LAST   = 6,
    parameter int VEND_FIRST = 16,
    parameter int BYP_REG    = 17,
    parameter int BYP_BIT    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          bypass
);

    localparam int NREG      = 1 << AW;
    localparam int VEND_LAST = NREG - 1;

    logic [DW-1:0] view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (reg_present(i, STD_LAST, VEND_FIRST, VEND_LAST)) begin : g_store
            logic [DW-1:0] val_d, val_q;

            always_comb begin
                val_d = val_q;
                if (!rst_n) begin
                    val_d = '0;
                end else if (wr_en && (wr_addr == AW'(i))) begin
                    val_d = wr_data;
                end
            end

            always_ff @(posedge clk) begin
                val_q <= val_d;
            end

            assign view[i] = val_q;
        end else begin : g_hole
            assign view[i] = '1;
        end
    end

    assign rd_data = view[rd_addr];
    assign bypass  = view[BYP_REG][BYP_BIT];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slave_pkg::*;
#(
    parameter int AW      = 5,
    parameter int DW      = 16,
    parameter int PRE_LEN = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic [AW-1:0] phy_addr,
    input  logic          bypass,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          frame_read,
    output logic          frame_match,
    output logic          mdio_o,
    output logic          mdio_oe
);

    localparam int OW = $clog2(PRE_LEN + 1);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        mdio_phase_e   ph;
        logic [OW-1:0] ones;
        logic [CW-1:0] cnt;
        logic          rd;
        logic [AW-1:0] phy;
        logic [AW-1:0] ra;
        logic          hit;
        logic [DW-1:0] sh;
        logic          out;
        logic          oe;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            MS_HUNT: begin
                if (mdio_i) begin
                    if (s_q.ones != OW'(PRE_LEN)) begin
                        s_d.ones = s_q.ones + 1'b1;
                    end
                end else if (s_q.ones == OW'(PRE_LEN)) begin
                    s_d.ph   = MS_START;
                    s_d.ones = '0;
                end else begin
                    s_d.ones = '0;
                end
            end
            MS_START: begin
                s_d.cnt = '0;
                s_d.ph  = mdio_i ? MS_OP : MS_HUNT;
            end
            MS_OP: begin
                if (s_q.cnt == '0) begin
                    s_d.rd  = mdio_i;
                    s_d.cnt = CW'(1);
                end else begin
                    s_d.cnt = '0;
                    // Only 10 (read) and 01 (write) are legal.
                    s_d.ph  = (s_q.rd != mdio_i) ? MS_PHY : MS_HUNT;
                end
            end
            MS_PHY: begin
                s_d.phy = {s_q.phy[AW-2:0], mdio_i};
                if (s_q.cnt == CW'(AW - 1)) begin
                    s_d.cnt = '0;
                    s_d.ph  = MS_REG;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            MS_REG: begin
                s_d.ra = {s_q.ra[AW-2:0], mdio_i};
                if (s_q.cnt == CW'(AW - 1)) begin
                    s_d.cnt = '0;
                    s_d.ph  = MS_TURN;
                    s_d.hit = bypass || (s_q.phy == phy_addr);
                    s_d.sh  = rd_data;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            MS_TURN: begin
                if (s_q.cnt == '0) begin
                    s_d.cnt = CW'(1);
                    if (s_q.rd) begin
                        s_d.oe  = s_q.hit;
                        s_d.out = 1'b0;
                    end else if (!mdio_i) begin
                        s_d.ph = MS_HUNT;
                    end
                end else begin
                    s_d.cnt = '0;
                    if (s_q.rd) begin
                        s_d.ph  = MS_DATA;
                        s_d.out = s_q.oe & s_q.sh[DW-1];
                        s_d.sh  = {s_q.sh[DW-2:0], 1'b0};
                    end else begin
                        s_d.ph = mdio_i ? MS_HUNT : MS_DATA;
                    end
                end
            end
            MS_DATA: begin
                if (s_q.rd) begin
                    s_d.out = s_q.oe & s_q.sh[DW-1];
                    s_d.sh  = {s_q.sh[DW-2:0], 1'b0};
                end else begin
                    s_d.sh = {s_q.sh[DW-2:0], mdio_i};
                end
                if (s_q.cnt == CW'(DW - 1)) begin
                    s_d.cnt  = '0;
                    s_d.ph   = MS_HUNT;
                    s_d.ones = '0;
                    s_d.oe   = 1'b0;
                    s_d.out  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.ph = MS_HUNT;
            end
        endcase

        if (!rst_n) begin
            s_d      = '0;
            s_d.ph   = MS_HUNT;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign rd_addr     = {s_q.ra[AW-2:0], mdio_i};
    assign wr_en       = (s_q.ph == MS_DATA) && !s_q.rd && s_q.hit
                         && (s_q.cnt == CW'(DW - 1));
    assign wr_addr     = s_q.ra;
    assign wr_data     = {s_q.sh[DW-2:0], mdio_i};
    assign frame_read  = s_q.rd;
    assign frame_match = s_q.hit;
    assign mdio_o      = s_q.out;
    assign mdio_oe     = s_q.oe;

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
    parameter int STRAP_W    = 3,
    parameter int AW         = 5,
    parameter int DW         = 16,
    parameter int PRE_LEN    = 32,
    parameter int STD_LAST   = 6,
    parameter int VEND_FIRST = 16,
    parameter int BYP_REG    = 17,
    parameter int BYP_BIT    = 3
) (
    input  logic               mdc,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] phyad_strap,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe
);

    logic [AW-1:0] phy_addr;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] wr_data;
    logic          wr_en;
    logic          bypass;
    logic          frame_read;
    logic          frame_match;

    mdio_strap_latch #(
        .SW (STRAP_W),
        .AW (AW)
    ) u_strap (
        .clk      (mdc),
        .rst_n    (rst_n),
        .strap    (phyad_strap),
        .phy_addr (phy_addr)
    );

    mdio_regfile #(
        .AW         (AW),
        .DW         (DW),
        .STD_LAST   (STD_LAST),
        .VEND_FIRST (VEND_FIRST),
        .BYP_REG    (BYP_REG),
        .BYP_BIT    (BYP_BIT)
    ) u_regs (
        .clk     (mdc),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .bypass  (bypass)
    );

    mdio_frame_fsm #(
        .AW      (AW),
        .DW      (DW),
        .PRE_LEN (PRE_LEN)
    ) u_fsm (
        .clk         (mdc),
        .rst_n       (rst_n),
        .mdio_i      (mdio_i),
        .phy_addr    (phy_addr),
        .bypass      (bypass),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_read  (frame_read),
        .frame_match (frame_match),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe)
    );

endmodule

// File: rtl/mdio_slave_checker.sv
module mdio_slave_checker #(
    parameter int AW      = 5,
    parameter int DW      = 16,
    parameter int HOLE_LO = 7,
    parameter int HOLE_HI = 15
) (
    input logic          mdc,
    input logic          rst_n,
    input logic          mdio_o,
    input logic          mdio_oe,
    input logic [AW-1:0] phy_addr,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          frame_read,
    input logic          frame_match
);

    localparam int RUN_MAX = DW + 1;
    localparam int RW      = $clog2(RUN_MAX + 2);

    logic [RW-1:0] oe_run_q;

    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            oe_run_q <= '0;
        end else if (mdio_oe) begin
            if (oe_run_q != '1) begin
                oe_run_q <= oe_run_q + 1'b1;
            end
        end else begin
            oe_run_q <= '0;
        end
    end

    AST_ADDR_FROZEN: assert property (@(posedge mdc) disable iff (!rst_n)
        $past(rst_n) |-> $stable(phy_addr));                           // R1
    AST_TURN_LOW: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);                                   // R2
    AST_HOLE_ONES: assert property (@(posedge mdc) disable iff (!rst_n)
        ((rd_addr >= AW'(HOLE_LO)) && (rd_addr <= AW'(HOLE_HI))) |-> (rd_data == '1)); // R4
    AST_DRIVE_SERVED: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (frame_read && frame_match));                      // R5
    AST_OE_RUN_LIMIT: assert property (@(posedge mdc) disable iff (!rst_n)
        oe_run_q <= RW'(RUN_MAX));                                     // R8

endmodule

bind mdio_slave mdio_slave_checker #(
    .AW (AW),
    .DW (DW)
) u_chk (
    .mdc         (mdc),
    .rst_n       (rst_n),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .phy_addr    (phy_addr),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .frame_read  (frame_read),
    .frame_match (frame_match)
);

// File: tb/mdio_slave_bench.sv
module mdio_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap = 3'd5;
    logic       m_bit = 1'b1;
    logic       line;
    logic       mdio_o, mdio_oe;

    int n_run = 0, n_fail = 0, oe_cycles = 0;
    bit finished = 1'b0;

    logic [15:0] model [32];

    always #4 clk = ~clk;

    assign line = m_bit & (mdio_oe ? mdio_o : 1'b1);

    mdio_slave u_mdio_slave (
        .mdc         (clk),
        .rst_n       (rst_n),
        .phyad_strap (strap),
        .mdio_i      (line),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe)
    );

    function automatic bit present(input int a);
        return (a <= 6) || (a >= 16);
    endfunction

    function automatic logic [15:0] m_read(input int a);
        return present(a) ? model[a] : 16'hFFFF;
    endfunction

    function automatic bit m_match(input logic [4:0] phy);
        return model[17][3] || (phy == 5'd5);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic b);
        @(negedge clk);
        m_bit = b;
        if (mdio_oe) oe_cycles++;
    endtask

    task automatic header(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        repeat (pre) tick(1'b1);
        tick(1'b0); tick(1'b1);
        tick(op[1]); tick(op[0]);
        for (int i = 4; i >= 0; i--) tick(phy[i]);
        for (int i = 4; i >= 0; i--) tick(ra[i]);
    endtask

    task automatic raw_read(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                            output logic [15:0] d, output logic t1, output logic t2oe, output logic t2o,
                            output int oe_n);
        int base;
        base = oe_cycles;
        header(pre, op, phy, ra);
        tick(1'b1); t1 = mdio_oe;
        tick(1'b1); t2oe = mdio_oe; t2o = mdio_o;
        for (int i = 15; i >= 0; i--) begin
            tick(1'b1);
            d[i] = line;
        end
        tick(1'b1);
        oe_n = oe_cycles - base;
    endtask

    task automatic raw_write(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [1:0] ta, input logic [15:0] d, output int oe_n);
        int base;
        base = oe_cycles;
        header(pre, 2'b01, phy, ra);
        tick(ta[1]); tick(ta[0]);
        for (int i = 15; i >= 0; i--) tick(d[i]);
        tick(1'b1);
        oe_n = oe_cycles - base;
    endtask

    // Read through the model; checks data, turnaround and drive window.
    task automatic read_chk(input logic [4:0] phy, input logic [4:0] ra, input string tag);
        logic [15:0] d, e;
        logic t1, t2oe, t2o;
        int oe_n;
        bit hit;
        hit = m_match(phy);
        e = hit ? m_read(ra) : 16'hFFFF;
        raw_read(32, 2'b10, phy, ra, d, t1, t2oe, t2o, oe_n);
        chk(d == e, tag, 32'(d), 32'(e));
        if (hit) begin
            chk(!t1 && t2oe && !t2o, {tag, " R2 turnaround"}, {29'd0, t1, t2oe, t2o}, 32'b010);
            chk(oe_n == 17, {tag, " R8 drive window"}, 32'(oe_n), 32'd17);
        end else begin
            chk(oe_n == 0, {tag, " R5 silent"}, 32'(oe_n), 32'd0);
        end
    endtask

    task automatic write_mdl(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d, input string tag);
        int oe_n;
        bit hit;
        hit = m_match(phy);
        raw_write(32, phy, ra, 2'b10, d, oe_n);
        if (hit && present(int'(ra))) model[ra] = d;
        chk(oe_n == 0, {tag, " R8 no drive on write"}, 32'(oe_n), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hang expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic t1, t2oe, t2o;
        int oe_n;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 32; i++) model[i] = 16'h0000;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mdio_oe == 1'b0, "R8 reset oe", 32'(mdio_oe), 32'd0);
        repeat (3) @(negedge clk);
        strap = 3'd2;

        read_chk(5'd5, 5'd0, "R1 R2 read reg0 at strapped address");
        read_chk(5'd2, 5'd0, "R1 new strap value ignored");

        write_mdl(5'd5, 5'd3, 16'hA5C3, "R3 write reg3");
        read_chk(5'd5, 5'd3, "R3 readback reg3");
        write_mdl(5'd5, 5'd20, 16'h1234, "R3 write reg20");
        read_chk(5'd5, 5'd20, "R3 readback reg20");
        write_mdl(5'd5, 5'd6, 16'h8001, "R3 write reg6");
        write_mdl(5'd5, 5'd31, 16'h7FFE, "R3 write reg31");
        read_chk(5'd5, 5'd6, "R3 readback reg6");
        read_chk(5'd5, 5'd31, "R3 readback reg31");

        write_mdl(5'd5, 5'd9, 16'h0000, "R4 write hole");
        read_chk(5'd5, 5'd9, "R4 hole reads ones");
        read_chk(5'd5, 5'd7, "R4 hole 7");
        read_chk(5'd5, 5'd15, "R4 hole 15");

        write_mdl(5'd1, 5'd4, 16'hBEEF, "R5 foreign write");
        read_chk(5'd5, 5'd4, "R5 reg4 untouched");
        read_chk(5'd12, 5'd3, "R5 foreign read");

        write_mdl(5'd5, 5'd17, 16'h0008, "R6 set bypass");
        read_chk(5'd26, 5'd17, "R6 read via any address");
        write_mdl(5'd3, 5'd5, 16'h5555, "R6 write via any address");
        read_chk(5'd5, 5'd5, "R6 bypass write landed");
        write_mdl(5'd9, 5'd17, 16'h0000, "R6 clear bypass");
        read_chk(5'd9, 5'd5, "R6 bypass off again");

        raw_read(16, 2'b10, 5'd5, 5'd3, d, t1, t2oe, t2o, oe_n);
        chk(oe_n == 0, "R7 short preamble ignored", 32'(oe_n), 32'd0);
        raw_read(32, 2'b11, 5'd5, 5'd3, d, t1, t2oe, t2o, oe_n);
        chk(oe_n == 0, "R7 opcode 11 ignored", 32'(oe_n), 32'd0);
        raw_read(32, 2'b00, 5'd5, 5'd3, d, t1, t2oe, t2o, oe_n);
        chk(oe_n == 0, "R7 opcode 00 ignored", 32'(oe_n), 32'd0);
        raw_write(32, 5'd5, 5'd3, 2'b00, 16'h0000, oe_n);
        read_chk(5'd5, 5'd3, "R7 bad turnaround write dropped");
        raw_write(32, 5'd5, 5'd20, 2'b11, 16'h0000, oe_n);
        read_chk(5'd5, 5'd20, "R7 turnaround 11 write dropped");

        for (int k = 0; k < 60; k++) begin
            logic [4:0] ra, phy;
            logic [15:0] wd;
            ra  = 5'($urandom_range(0, 31));
            phy = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'd5;
            wd  = 16'($urandom);
            if ($urandom_range(0, 1) == 1) write_mdl(phy, ra, wd, "R3 R6 random write");
            else read_chk(phy, ra, "R3 R4 R5 R6 random read");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule